// File: doc/BRIEF.md
# Gate Drive Interlock Supervisor

A synchronous digital supervisor placed between a pair of PWM commands (one for the high-side switch, one for the low-side switch) and the two gate-enable outputs of a step-down power stage. It keeps both switches off until the supply is reported good. It qualifies high-side command pulses by their minimum high and low widths. It blanks the high-side output when both commands stay high for too long. It holds the high-side output off while a digital temperature reading is above a hot threshold, and releases it only below a lower threshold. Every interval is a count of system clock cycles. The defaults assume a 500 MHz clock, so 12 ns, 17 ns and 30 ns become 6, 9 and 15 cycles.

The high side is run by a state machine with six states. HS_HOLD is entered whenever the supply is not good. HS_HOLD goes to HS_IDLE on the first edge with the supply good. HS_IDLE goes to HS_QUAL when the high-side command is sampled high. HS_QUAL returns to HS_IDLE if the command falls early, and goes to HS_DRIVE once the command has been high for the minimum on-time. HS_DRIVE goes to HS_RECOVER when the command falls. HS_RECOVER goes to HS_IDLE after the minimum number of consecutive low samples; a high sample in HS_RECOVER restarts that low count. Any of HS_IDLE, HS_QUAL, HS_DRIVE or HS_RECOVER goes to HS_BLANK on an overlap trip. HS_BLANK goes back to HS_IDLE as soon as the overlap ends.

The low side follows its command one cycle later. A separate thermal latch gates only the high side. Each output's drive-strength select bit is passed through a register. A sticky three-bit status word records overlap trips, thermal trips and losses of supply, and each bit is cleared by writing one to its clear strobe.

Top module: `gate_interlock_sup`

## Requirements
- R1: While rst_n is low, gate_hi, gate_lo, str_hi_out, str_lo_out and status_flags are all zero.
- R2: While supply_ok is low, gate_hi and gate_lo are low in the same cycle, with no clock edge needed. Loss of supply clears the overlap timer, the pulse qualifier and the thermal latch. After supply_ok returns, a high-side command that is already high must qualify again as in R4, starting one edge later.
- R3: With the supply good, gate_lo equals the cmd_lo value sampled at the previous clock edge.
- R4: gate_hi rises at the edge where cmd_hi has been sampled high for MIN_ON_CYC (6) consecutive edges, starting from HS_IDLE. A shorter high time gives no output pulse. gate_hi falls at the first edge that samples cmd_hi low.
- R5: After a high-side output pulse, cmd_hi must be sampled low for MIN_OFF_CYC (9) consecutive edges before a new pulse can start. A high sample before then restarts the low count and is ignored, however long it lasts.
- R6: The edge that samples both commands high for the (OVL_LIMIT+1)-th (16th) consecutive time forces gate_hi low. An overlap of exactly OVL_LIMIT (15) samples has no effect.
- R7: Once either command is sampled low during an overlap blank, the high side returns to HS_IDLE. A cmd_hi that is still high then qualifies afresh under R4, so gate_hi comes back after MIN_ON_CYC+1 samples counted from the release sample.
- R8: A temp_code sampled above HOT_SET (150) forces gate_hi low from that edge on. The value 150 itself does not trip. temp_code is an unsigned reading in whole degrees Celsius. gate_lo is not affected.
- R9: Once tripped, the thermal hold releases only at an edge that samples temp_code below HOT_CLR (134). If the high side is still in HS_DRIVE, gate_hi returns at that same edge.
- R10: str_hi_out and str_lo_out equal str_hi_sel and str_lo_sel as sampled at the previous edge (0 selects half strength, 1 selects full strength).
- R11: The status_flags bits are sticky: bit 0 records an overlap trip, bit 1 a thermal trip, and bit 2 a fall of supply_ok after it was sampled high. A one on bit i of status_clr clears bit i at the next edge. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Gate-drive supply within range |
| cmd_hi | input | 1 | High-side PWM command |
| cmd_lo | input | 1 | Low-side PWM command |
| temp_code | input | TEMP_W (8) | Die temperature in degrees Celsius, unsigned |
| str_hi_sel | input | 1 | High-side strength select |
| str_lo_sel | input | 1 | Low-side strength select |
| status_clr | input | 3 | Per-bit clear strobe for status_flags |
| gate_hi | output | 1 | High-side gate enable |
| gate_lo | output | 1 | Low-side gate enable |
| str_hi_out | output | 1 | Registered high-side strength select |
| str_lo_out | output | 1 | Registered low-side strength select |
| status_flags | output | 3 | Sticky fault flags: overlap, thermal, supply loss |

## Verification
A qualifier state machine stuck in HS_QUAL or HS_RECOVER shows at gate_hi as a missing or extra pulse. It appears within MIN_ON_CYC or MIN_OFF_CYC edges of the command edge that should have moved the machine on. An overlap counter that does not clear or does not saturate shows as gate_hi dropping too early or too late. The difference is exactly one edge either side of the 16th overlapping sample. A thermal latch with wrong hysteresis shows at gate_hi on the first edge that samples a code between 134 and 150. A latch that survives a supply loss shows as gate_hi staying low after requalification.

// File: rtl/gis_pkg.sv
package gis_pkg;

    typedef enum logic [2:0] {
        HS_HOLD,
        HS_IDLE,
        HS_QUAL,
        HS_DRIVE,
        HS_RECOVER,
        HS_BLANK
    } hs_state_t;

    localparam int FLAG_OVL = 0;
    localparam int FLAG_HOT = 1;
    localparam int FLAG_UV  = 2;
    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/gis_overlap_timer.sv
module gis_overlap_timer #(
    parameter int OVL_LIMIT = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic cmd_hi,
    input  logic cmd_lo,
    output logic overlap,
    output logic ov_trip
);
    localparam int OW = $clog2(OVL_LIMIT + 1);
    localparam logic [OW-1:0] OV_TOP = OW'(OVL_LIMIT);

    logic [OW-1:0] ov_cnt;

    assign overlap = cmd_hi && cmd_lo;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ov_cnt <= '0;
        end else if (!supply_ok || !overlap) begin
            ov_cnt <= '0;
        end else if (ov_cnt != OV_TOP) begin
            ov_cnt <= ov_cnt + OW'(1);
        end
    end

    // Trips on the sample after OVL_LIMIT overlapping samples
    assign ov_trip = overlap && (ov_cnt == OV_TOP);

endmodule

// File: rtl/gis_hs_fsm.sv
module gis_hs_fsm
    import gis_pkg::*;
#(
    parameter int MIN_ON_CYC  = 6,
    parameter int MIN_OFF_CYC = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic cmd_hi,
    input  logic overlap,
    input  logic ov_trip,
    output logic hs_drive,
    output logic trip_evt
);
    localparam int MAXW = (MIN_ON_CYC > MIN_OFF_CYC) ? MIN_ON_CYC : MIN_OFF_CYC;
    localparam int CW   = $clog2(MAXW + 1);
    localparam logic [CW-1:0] ON_LAST  = CW'(MIN_ON_CYC - 1);
    localparam logic [CW-1:0] OFF_LAST = CW'(MIN_OFF_CYC - 1);

    hs_state_t     state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          can_trip;

    assign can_trip = supply_ok && ov_trip &&
                      (state != HS_BLANK) && (state != HS_HOLD);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= HS_HOLD;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next-state and qualification counter
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        if (!supply_ok) begin
            state_n = HS_HOLD;
            cnt_n   = '0;
        end else begin
            unique case (state)
                HS_HOLD: begin
                    state_n = HS_IDLE;
                    cnt_n   = '0;
                end
                HS_IDLE: begin
                    if (cmd_hi) begin
                        state_n = HS_QUAL;
                        cnt_n   = CW'(1);
                    end
                end
                HS_QUAL: begin
                    if (!cmd_hi) begin
                        state_n = HS_IDLE;
                        cnt_n   = '0;
                    end else if (cnt == ON_LAST) begin
                        state_n = HS_DRIVE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
                HS_DRIVE: begin
                    if (!cmd_hi) begin
                        state_n = HS_RECOVER;
                        cnt_n   = CW'(1);
                    end
                end
                HS_RECOVER: begin
                    if (cmd_hi) begin
                        cnt_n = '0;
                    end else if (cnt == OFF_LAST) begin
                        state_n = HS_IDLE;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + CW'(1);
                    end
                end
                HS_BLANK: begin
                    if (!overlap) begin
                        state_n = HS_IDLE;
                        cnt_n   = '0;
                    end
                end
                default: begin
                    state_n = HS_HOLD;
                    cnt_n   = '0;
                end
            endcase
            if (can_trip) begin
                state_n = HS_BLANK;
                cnt_n   = '0;
            end
        end
    end

    // Outputs
    always_comb begin
        hs_drive = (state == HS_DRIVE);
        trip_evt = can_trip;
    end

endmodule

// File: rtl/gis_thermal_latch.sv
module gis_thermal_latch #(
    parameter int TEMP_W  = 8,
    parameter int HOT_SET = 150,
    parameter int HOT_CLR = 134
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              hot,
    output logic              hot_evt
);
    localparam logic [TEMP_W-1:0] SET_CODE = TEMP_W'(HOT_SET);
    localparam logic [TEMP_W-1:0] CLR_CODE = TEMP_W'(HOT_CLR);

    logic above, below;

    assign above   = temp_code > SET_CODE;
    assign below   = temp_code < CLR_CODE;
    assign hot_evt = supply_ok && !hot && above;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hot <= 1'b0;
        end else if (!supply_ok) begin
            hot <= 1'b0;
        end else if (above) begin
            hot <= 1'b1;
        end else if (below) begin
            hot <= 1'b0;
        end
    end

endmodule

// File: rtl/gis_status_reg.sv
module gis_status_reg #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr_strobe,
    output logic [N-1:0] flags
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (flags & ~clr_strobe) | set_evt;
        end
    end

endmodule

// File: rtl/gate_interlock_sup.sv
module gate_interlock_sup
    import gis_pkg::*;
#(
    parameter int MIN_ON_CYC  = 6,
    parameter int MIN_OFF_CYC = 9,
    parameter int OVL_LIMIT   = 15,
    parameter int TEMP_W      = 8,
    parameter int HOT_SET     = 150,
    parameter int HOT_CLR     = 134
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_ok,
    input  logic              cmd_hi,
    input  logic              cmd_lo,
    input  logic [TEMP_W-1:0] temp_code,
    input  logic              str_hi_sel,
    input  logic              str_lo_sel,
    input  logic [2:0]        status_clr,
    output logic              gate_hi,
    output logic              gate_lo,
    output logic              str_hi_out,
    output logic              str_lo_out,
    output logic [2:0]        status_flags
);
    logic overlap, ov_trip, hs_drive, trip_evt, hot, hot_evt;
    logic ok_q, lo_q;
    logic [NUM_FLAGS-1:0] flag_set;

    gis_overlap_timer #(.OVL_LIMIT(OVL_LIMIT)) u_ovl (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .overlap(overlap), .ov_trip(ov_trip)
    );

    gis_hs_fsm #(.MIN_ON_CYC(MIN_ON_CYC), .MIN_OFF_CYC(MIN_OFF_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .cmd_hi(cmd_hi), .overlap(overlap), .ov_trip(ov_trip),
        .hs_drive(hs_drive), .trip_evt(trip_evt)
    );

    gis_thermal_latch #(.TEMP_W(TEMP_W), .HOT_SET(HOT_SET), .HOT_CLR(HOT_CLR)) u_therm (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .temp_code(temp_code), .hot(hot), .hot_evt(hot_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q       <= 1'b0;
            lo_q       <= 1'b0;
            str_hi_out <= 1'b0;
            str_lo_out <= 1'b0;
        end else begin
            ok_q       <= supply_ok;
            lo_q       <= supply_ok && cmd_lo;
            str_hi_out <= str_hi_sel;
            str_lo_out <= str_lo_sel;
        end
    end

    always_comb begin
        flag_set           = '0;
        flag_set[FLAG_OVL] = trip_evt;
        flag_set[FLAG_HOT] = hot_evt;
        flag_set[FLAG_UV]  = ok_q && !supply_ok;
    end

    gis_status_reg #(.N(NUM_FLAGS)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_evt(flag_set),
        .clr_strobe(status_clr), .flags(status_flags)
    );

    // Supply loss removes drive without waiting for a clock edge
    assign gate_hi = supply_ok && hs_drive && !hot;
    assign gate_lo = supply_ok && lo_q;

endmodule

// File: rtl/gis_checker.sv
module gis_checker #(
    parameter int OVL_LIMIT = 15,
    parameter int TEMP_W    = 8,
    parameter int HOT_SET   = 150
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_ok,
    input logic              cmd_hi,
    input logic              cmd_lo,
    input logic [TEMP_W-1:0] temp_code,
    input logic              str_hi_sel,
    input logic              gate_hi,
    input logic              gate_lo,
    input logic              str_hi_out,
    input logic [2:0]        status_clr,
    input logic [2:0]        status_flags
);
    localparam int BW = $clog2(OVL_LIMIT + 2);
    localparam logic [BW-1:0] B_TOP = BW'(OVL_LIMIT + 1);
    localparam logic [TEMP_W-1:0] SET_CODE = TEMP_W'(HOT_SET);

    logic          warm;
    logic [BW-1:0] both_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm     <= 1'b0;
            both_cnt <= '0;
        end else begin
            warm <= 1'b1;
            if (!(gate_hi && gate_lo)) both_cnt <= '0;
            else if (both_cnt != B_TOP) both_cnt <= both_cnt + BW'(1);
        end
    end

    // R2: both gates stay off without supply
    a_r2_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> (!gate_hi && !gate_lo));

    // R3: low side tracks its command one edge later
    a_r3_lo_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && supply_ok && $past(supply_ok)) |-> (gate_lo == $past(cmd_lo)));

    // R4: high side only rises after a high command sample
    a_r4_rise_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $rose(gate_hi)) |-> $past(cmd_hi));

    // R6: both gates never on together longer than the limit
    a_r6_overlap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        both_cnt <= BW'(OVL_LIMIT));

    // R8: a hot sample removes high-side drive
    a_r8_hot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && ($past(temp_code) > SET_CODE)) |-> !gate_hi);

    // R10: strength select registered
    a_r10_strength: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (str_hi_out == $past(str_hi_sel)));

    // R11: flags drop only through a clear strobe
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> ((($past(status_flags) & ~$past(status_clr)) & ~status_flags) == 3'b000));

endmodule

bind gate_interlock_sup gis_checker #(
    .OVL_LIMIT(OVL_LIMIT), .TEMP_W(TEMP_W), .HOT_SET(HOT_SET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cmd_hi(cmd_hi),
    .cmd_lo(cmd_lo), .temp_code(temp_code), .str_hi_sel(str_hi_sel),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .str_hi_out(str_hi_out),
    .status_clr(status_clr), .status_flags(status_flags)
);

// File: tb/gate_interlock_sup_test.sv
module gate_interlock_sup_test;
    localparam int MIN_ON  = 6;
    localparam int MIN_OFF = 9;
    localparam int OVL     = 15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       supply_ok = 1'b0;
    logic       cmd_hi = 1'b0;
    logic       cmd_lo = 1'b0;
    logic [7:0] temp_code = 8'd25;
    logic       str_hi_sel = 1'b0;
    logic       str_lo_sel = 1'b0;
    logic [2:0] status_clr = 3'b000;
    logic       gate_hi, gate_lo, str_hi_out, str_lo_out;
    logic [2:0] status_flags;

    int checks = 0;
    int errors = 0;

    bit [1:0] q_exp[$];
    string    q_tag[$];

    always #10 clk = ~clk;

    gate_interlock_sup uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cmd_hi(cmd_hi),
        .cmd_lo(cmd_lo), .temp_code(temp_code), .str_hi_sel(str_hi_sel),
        .str_lo_sel(str_lo_sel), .status_clr(status_clr), .gate_hi(gate_hi),
        .gate_lo(gate_lo), .str_hi_out(str_hi_out), .str_lo_out(str_lo_out),
        .status_flags(status_flags)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Driver: one cycle of stimulus plus expected {gate_hi, gate_lo} after the edge
    task automatic cyc(input bit h, input bit l, input bit ok, input int t,
                       input bit eh, input bit el, input string tag);
        @(negedge clk);
        cmd_hi    = h;
        cmd_lo    = l;
        supply_ok = ok;
        temp_code = t[7:0];
        q_exp.push_back({eh, el});
        q_tag.push_back(tag);
    endtask

    task automatic hs_pulse(input int len, input int gap, input string tag);
        for (int k = 1; k <= len; k++) cyc(1, 0, 1, 25, k >= MIN_ON, 0, tag);
        for (int g = 0; g < gap; g++) cyc(0, 0, 1, 25, 0, 0, tag);
    endtask

    // Monitor: compare outputs after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() > 0) begin
                bit [1:0] e;
                string    t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                chk(t, {gate_hi, gate_lo}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 reset state
        str_hi_sel = 1'b1;
        str_lo_sel = 1'b1;
        cmd_hi = 1'b1;
        cmd_lo = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 gates", {gate_hi, gate_lo}, 0);
        chk("R1 strength", {str_hi_out, str_lo_out}, 0);
        chk("R1 flags", status_flags, 0);
        cmd_hi = 1'b0;
        cmd_lo = 1'b0;
        str_lo_sel = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 strength a", {str_hi_out, str_lo_out}, 2'b10);
        str_hi_sel = 1'b0;
        str_lo_sel = 1'b1;
        @(negedge clk);
        chk("R10 strength b", {str_hi_out, str_lo_out}, 2'b01);

        // R2 hold while supply not good
        for (int i = 0; i < 20; i++) cyc(1, 1, 0, 25, 0, 0, "R2 hold");
        cyc(0, 0, 0, 25, 0, 0, "R2 hold");
        cyc(0, 0, 1, 25, 0, 0, "R2 power-up");
        chk("R11 no uv at first power-up", status_flags, 0);

        // R3 low side follows
        cyc(0, 1, 1, 25, 0, 1, "R3");
        cyc(0, 0, 1, 25, 0, 0, "R3");
        cyc(0, 1, 1, 25, 0, 1, "R3");
        cyc(0, 1, 1, 25, 0, 1, "R3");
        cyc(0, 0, 1, 25, 0, 0, "R3");

        // R4 minimum on-time
        hs_pulse(MIN_ON - 1, 2, "R4 short");
        hs_pulse(MIN_ON, MIN_OFF, "R4 exact");
        hs_pulse(12, MIN_OFF, "R4 long");

        // R5 minimum off-time
        hs_pulse(10, MIN_OFF - 1, "R5 first");
        for (int i = 0; i < 10; i++) cyc(1, 0, 1, 25, 0, 0, "R5 ignored");
        for (int i = 0; i < MIN_OFF; i++) cyc(0, 0, 1, 25, 0, 0, "R5 gap");
        hs_pulse(8, MIN_OFF, "R5 after gap");

        // R6 overlap boundary then trip, R7 release
        for (int k = 1; k <= 10; k++) cyc(1, 0, 1, 25, k >= MIN_ON, 0, "R6 lead");
        for (int j = 1; j <= OVL; j++) cyc(1, 1, 1, 25, 1, 1, "R6 at limit");
        cyc(1, 0, 1, 25, 1, 0, "R6 at limit end");
        chk("R6 no trip flag", status_flags, 0);
        for (int j = 1; j <= OVL + 5; j++) cyc(1, 1, 1, 25, j <= OVL, 1, "R6 trip");
        for (int m = 1; m <= 10; m++) cyc(1, 0, 1, 25, m >= MIN_ON + 1, 0, "R7 requalify");
        for (int g = 0; g < MIN_OFF; g++) cyc(0, 0, 1, 25, 0, 0, "R7 gap");
        chk("R11 overlap flag", status_flags, 3'b001);
        cyc(0, 0, 1, 25, 0, 0, "R11 clear");
        status_clr = 3'b001;
        cyc(0, 0, 1, 25, 0, 0, "R11 clear");
        status_clr = 3'b000;
        chk("R11 cleared", status_flags, 0);

        // R8 / R9 thermal with hysteresis
        for (int k = 1; k <= 8; k++) cyc(1, 0, 1, 25, k >= MIN_ON, 0, "R8 lead");
        cyc(1, 0, 1, 150, 1, 0, "R8 at threshold");
        cyc(1, 0, 1, 151, 0, 0, "R8 trip");
        cyc(1, 1, 1, 200, 0, 1, "R8 low side unaffected");
        cyc(1, 0, 1, 200, 0, 0, "R8 hot");
        cyc(1, 0, 1, 140, 0, 0, "R9 hysteresis");
        cyc(1, 0, 1, 134, 0, 0, "R9 at release");
        cyc(1, 0, 1, 133, 1, 0, "R9 release");
        cyc(1, 0, 1, 25, 1, 0, "R9 cool");
        chk("R11 thermal flag", status_flags, 3'b010);

        // R2 immediate removal on supply loss
        @(negedge clk);
        supply_ok = 1'b0;
        #1;
        chk("R2 immediate", {gate_hi, gate_lo}, 0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 25, 0, 0, "R2 off");
        chk("R11 uv flag", status_flags, 3'b110);
        for (int m = 1; m <= 10; m++) cyc(1, 0, 1, 25, m >= MIN_ON + 1, 0, "R2 requalify");

        // R2 supply loss clears the thermal latch
        cyc(1, 0, 1, 200, 0, 0, "R2 hot before loss");
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 140, 0, 0, "R2 off hot");
        for (int m = 1; m <= 10; m++) cyc(1, 0, 1, 140, m >= MIN_ON + 1, 0, "R2 latch cleared");
        for (int g = 0; g < MIN_OFF; g++) cyc(0, 0, 1, 25, 0, 0, "R2 gap");

        // R11 clear all
        status_clr = 3'b111;
        @(negedge clk);
        status_clr = 3'b000;
        chk("R11 clear all", status_flags, 0);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule